// File: doc/BRIEF.md
# Bus Fault Status Capture Registers

This block records why and where a bus access faulted. A fault detector elsewhere in the chip classifies each bad access. It then hands the block the fault class, the direction, the access size, the 24-bit address and the current parity-interrupt-enable setting. The block turns that report into three 16-bit status words:

- a general status word, whose fixed code depends on the fault class and direction;
- a lower address word;
- an upper word that merges a size and byte-lane code with the high address bits.

In the same cycle that the words are written, the block raises a one-cycle bus-error pulse.

Software reads the three words through a small register port. It can overwrite the general status word directly. A clear strobe resets all three words to the all-ones "nothing recorded" value.

Fault reports arrive over a valid/ready interface. The block never applies back-pressure. `flt_ready` is low only while reset is asserted, and it rises on the first clock edge after reset is released. A report is accepted in any cycle where `flt_valid` and `flt_ready` are both high. A report offered while `flt_ready` is low is ignored. The register port and the clear strobe are plain single-cycle controls.

Top module: `fault_status_capture`

## Requirements
- R1: After reset, all three status words read 0xFFFF, `bus_err` is low, and `flt_ready` is high from the first clock edge after reset is released.
- R2: An accepted page-not-present fault (`flt_kind`=0) loads the general status word with 0x8BFF for a write (`flt_write`=1) or 0xCBFF for a read.
- R3: An accepted user I/O-space fault (`flt_kind`=1) loads the general status word with 0x9AFF for a write or 0xDAFF for a read.
- R4: When `par_irq_en` is high for a page or user I/O fault, bit 10 (0x0400) is also set in the loaded general status word.
- R5: A kernel-area fault (`flt_kind`=2) or a write-protect fault (`flt_kind`=3) leaves the general status word unchanged, but still loads both address words and still pulses `bus_err`.
- R6: For any accepted fault, the upper address word (`reg_sel`=1) is loaded as follows:
  - 0x7C00 when `flt_size` is 1 (word) or 2 or 3 (long);
  - 0x7D00 for a byte access (`flt_size`=0) at an odd address;
  - 0x7E00 for a byte access at an even address;
  - in every case, ORed with address bits 23:16 in bits 7:0.
- R7: For any accepted fault, the lower address word (`reg_sel`=2) is loaded with address bits 15:0.
- R8: A cycle with `clr_stb` high sets all three words to 0xFFFF. Where it conflicts with a CPU write, the clear wins.
- R9: A CPU write (`reg_wr`=1) with `reg_sel`=0 loads the general status word from `reg_wdata`. Writes with `reg_sel` of 1, 2 or 3 change no register. A read with `reg_sel`=3 returns 0xFFFF.
- R10: A fault capture takes priority over a same-cycle CPU write or clear for every word that the fault loads. Words that the fault does not load follow R8 and R9.
- R11: `bus_err` is high for exactly the one cycle in which the captured words first become visible, and it is low in every cycle that follows no accepted fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_valid | input | 1 | Fault report offered |
| flt_ready | output | 1 | Fault report can be accepted (held high after reset) |
| flt_kind | input | 2 | 0 page not present, 1 user I/O space, 2 kernel area, 3 write protect |
| flt_write | input | 1 | 1 = faulting access was a write |
| flt_size | input | 2 | 0 byte, 1 word, 2 or 3 long |
| flt_addr | input | 24 | Faulting address |
| par_irq_en | input | 1 | Parity interrupt enable, folded into the general status code |
| reg_sel | input | 2 | 0 general status, 1 upper address word, 2 lower address word, 3 unused |
| reg_wr | input | 1 | CPU write strobe |
| reg_wdata | input | 16 | CPU write data |
| clr_stb | input | 1 | Clear-status strobe |
| reg_rdata | output | 16 | Read data for `reg_sel` (combinational) |
| bus_err | output | 1 | One-cycle bus-error pulse |

## Verification
The bench sweeps every combination of fault class, direction, size code and parity enable, over addresses chosen to cover odd and even byte lanes and distinct high bytes. Before each fault it presets the general status word to a marker value. This exposes a design that lets kernel-area or write-protect faults overwrite general status, swaps the odd and even byte-lane codes, or drops the parity bit.

Same-cycle collisions are also driven:
- fault with clear;
- fault with CPU write;
- clear with CPU write.

A design with the wrong priority would lose the captured words. Writes aimed at the read-only address words are checked to leave them untouched. `bus_err` is checked both in the capture cycle and in the cycle after, which catches a stretched or late pulse.

// File: rtl/fbsc_pkg.sv
package fbsc_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    FK_PAGE   = 2'd0,
    FK_USERIO = 2'd1,
    FK_KERNEL = 2'd2,
    FK_WPROT  = 2'd3
  } fault_kind_e;

  typedef enum logic [1:0] {
    SEL_GEN  = 2'd0,
    SEL_UPR  = 2'd1,
    SEL_LWR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam logic [WORD_W-1:0] IDLE_WORD  = 16'hFFFF;
  localparam logic [WORD_W-1:0] PAR_BIT    = 16'h0400;
  localparam logic [WORD_W-1:0] CODE_PG_WR = 16'h8BFF;
  localparam logic [WORD_W-1:0] CODE_PG_RD = 16'hCBFF;
  localparam logic [WORD_W-1:0] CODE_IO_WR = 16'h9AFF;
  localparam logic [WORD_W-1:0] CODE_IO_RD = 16'hDAFF;
  localparam logic [WORD_W-1:0] LANE_WIDE  = 16'h7C00;
  localparam logic [WORD_W-1:0] LANE_ODD   = 16'h7D00;
  localparam logic [WORD_W-1:0] LANE_EVEN  = 16'h7E00;

  typedef struct packed {
    logic              gen_load;
    logic [WORD_W-1:0] gen_word;
    logic [WORD_W-1:0] upr_word;
    logic [WORD_W-1:0] lwr_word;
  } capture_t;

endpackage

// File: rtl/fbsc_encoder.sv
module fbsc_encoder
  import fbsc_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [1:0]        kind,
  input  logic              is_write,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic              par_en,
  output capture_t          cap
);
  localparam int HI_W  = ADDR_W - WORD_W;
  localparam int PAD_W = WORD_W - HI_W;

  fault_kind_e       kind_e;
  logic [WORD_W-1:0] base_code;
  logic [WORD_W-1:0] lane_code;
  logic [WORD_W-1:0] hi_bits;

  assign kind_e  = fault_kind_e'(kind);
  assign hi_bits = {{PAD_W{1'b0}}, addr[ADDR_W-1:WORD_W]};

  always_comb begin
    base_code = IDLE_WORD;
    unique case (kind_e)
      FK_PAGE:   base_code = is_write ? CODE_PG_WR : CODE_PG_RD;
      FK_USERIO: base_code = is_write ? CODE_IO_WR : CODE_IO_RD;
      default:   base_code = IDLE_WORD;
    endcase
  end

  always_comb begin
    if (size == 2'd0) lane_code = addr[0] ? LANE_ODD : LANE_EVEN;
    else              lane_code = LANE_WIDE;
  end

  always_comb begin
    cap.gen_load = (kind_e == FK_PAGE) || (kind_e == FK_USERIO);
    cap.gen_word = base_code | (par_en ? PAR_BIT : '0);
    cap.upr_word = lane_code | hi_bits;
    cap.lwr_word = addr[WORD_W-1:0];
  end
endmodule

// File: rtl/fbsc_regfile.sv
module fbsc_regfile
  import fbsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  capture_t          cap,
  input  logic              cpu_gen_wr,
  input  logic [WORD_W-1:0] cpu_wdata,
  input  logic              clr,
  output logic [WORD_W-1:0] gen_q,
  output logic [WORD_W-1:0] upr_q,
  output logic [WORD_W-1:0] lwr_q,
  output logic              berr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= IDLE_WORD;
      upr_q  <= IDLE_WORD;
      lwr_q  <= IDLE_WORD;
      berr_q <= 1'b0;
    end else begin
      berr_q <= take;
      if (take && cap.gen_load) gen_q <= cap.gen_word;
      else if (clr)             gen_q <= IDLE_WORD;
      else if (cpu_gen_wr)      gen_q <= cpu_wdata;
      if (take) begin
        upr_q <= cap.upr_word;
        lwr_q <= cap.lwr_word;
      end else if (clr) begin
        upr_q <= IDLE_WORD;
        lwr_q <= IDLE_WORD;
      end
    end
  end

  AST_BERR_FOLLOWS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> berr_q); // R11
  AST_BERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !berr_q); // R11
  AST_LWR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (lwr_q == $past(cap.lwr_word))); // R7
  AST_GEN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cap.gen_load && !clr && !cpu_gen_wr) |=> $stable(gen_q)); // R5
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !take) |=> (gen_q == IDLE_WORD && upr_q == IDLE_WORD && lwr_q == IDLE_WORD)); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clr) |=> ($stable(upr_q) && $stable(lwr_q))); // R9
endmodule

// File: rtl/fbsc_readmux.sv
module fbsc_readmux
  import fbsc_pkg::*;
#(
  parameter int NREG = 3
) (
  input  logic [1:0]             sel,
  input  logic [NREG*WORD_W-1:0] regs_flat,
  output logic [WORD_W-1:0]      rdata
);
  localparam int NSLOT = 4;
  logic [WORD_W-1:0] slot [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g < NREG) begin : g_live
      assign slot[g] = regs_flat[g*WORD_W +: WORD_W];
    end else begin : g_idle
      assign slot[g] = IDLE_WORD;
    end
  end

  assign rdata = slot[sel];
endmodule

// File: rtl/fault_status_capture.sv
module fault_status_capture
  import fbsc_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_valid,
  output logic              flt_ready,
  input  logic [1:0]        flt_kind,
  input  logic              flt_write,
  input  logic [1:0]        flt_size,
  input  logic [ADDR_W-1:0] flt_addr,
  input  logic              par_irq_en,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [15:0]       reg_wdata,
  input  logic              clr_stb,
  output logic [15:0]       reg_rdata,
  output logic              bus_err
);
  localparam int NREG = 3;

  capture_t          cap;
  logic              take;
  logic              rdy_q;
  logic [WORD_W-1:0] gen_q, upr_q, lwr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign flt_ready = rdy_q;
  assign take      = flt_valid && rdy_q;

  fbsc_encoder #(.ADDR_W(ADDR_W)) u_enc (
    .kind(flt_kind), .is_write(flt_write), .size(flt_size),
    .addr(flt_addr), .par_en(par_irq_en), .cap(cap)
  );

  fbsc_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .take(take), .cap(cap),
    .cpu_gen_wr(reg_wr && (reg_sel == SEL_GEN)), .cpu_wdata(reg_wdata),
    .clr(clr_stb), .gen_q(gen_q), .upr_q(upr_q), .lwr_q(lwr_q), .berr_q(bus_err)
  );

  fbsc_readmux #(.NREG(NREG)) u_rd (
    .sel(reg_sel), .regs_flat({lwr_q, upr_q, gen_q}), .rdata(reg_rdata)
  );

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> flt_ready); // R1
  AST_PRIORITY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && clr_stb) |=> (lwr_q == $past(flt_addr[15:0]))); // R10
endmodule

// File: tb/fault_status_capture_bench.sv
module fault_status_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_valid = 1'b0;
  logic        flt_ready;
  logic [1:0]  flt_kind = '0;
  logic        flt_write = 1'b0;
  logic [1:0]  flt_size = '0;
  logic [23:0] flt_addr = '0;
  logic        par_irq_en = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic        clr_stb = 1'b0;
  logic [15:0] reg_rdata;
  logic        bus_err;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fault_status_capture u_fault_status_capture (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_ready(flt_ready),
    .flt_kind(flt_kind), .flt_write(flt_write), .flt_size(flt_size),
    .flt_addr(flt_addr), .par_irq_en(par_irq_en), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .clr_stb(clr_stb),
    .reg_rdata(reg_rdata), .bus_err(bus_err)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] v);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  task automatic cpu_wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk);
    clr_stb = 1'b1;
    @(negedge clk);
    clr_stb = 1'b0;
  endtask

  function automatic logic [15:0] exp_gen(input int k, input bit w, input bit p, input logic [15:0] prev);
    logic [15:0] v;
    if (k == 0)      v = w ? 16'h8BFF : 16'hCBFF;
    else if (k == 1) v = w ? 16'h9AFF : 16'hDAFF;
    else return prev;
    return p ? (v | 16'h0400) : v;
  endfunction

  function automatic logic [15:0] exp_upr(input int s, input logic [23:0] a);
    logic [15:0] v;
    if (s == 0) v = a[0] ? 16'h7D00 : 16'h7E00;
    else        v = 16'h7C00;
    return v | {8'h00, a[23:16]};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R11 actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [23:0] addrs [4];
    addrs[0] = 24'h000000; addrs[1] = 24'hA5C3F1;
    addrs[2] = 24'h3F7E02; addrs[3] = 24'hFFFFFF;

    #1 v = reg_rdata;
    chk("R1 ready low in reset", {15'b0, flt_ready}, 16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", {15'b0, flt_ready}, 16'h0001);
    chk("R1 bus_err", {15'b0, bus_err}, 16'h0000);
    rd(2'd0, v); chk("R1 gen", v, 16'hFFFF);
    rd(2'd1, v); chk("R1 upr", v, 16'hFFFF);
    rd(2'd2, v); chk("R1 lwr", v, 16'hFFFF);
    rd(2'd3, v); chk("R9 unused slot", v, 16'hFFFF);

    for (int k = 0; k < 4; k++)
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < 4; s++)
          for (int p = 0; p < 2; p++)
            for (int a = 0; a < 4; a++) begin
              logic [15:0] mark;
              mark = 16'h1000 + 16'(k*64 + w*32 + s*8 + p*4 + a);
              cpu_wr(2'd0, mark);
              @(negedge clk);
              flt_kind = 2'(k); flt_write = w[0]; flt_size = 2'(s);
              flt_addr = addrs[a]; par_irq_en = p[0]; flt_valid = 1'b1;
              @(negedge clk);
              flt_valid = 1'b0;
              chk("R11 pulse", {15'b0, bus_err}, 16'h0001);
              rd(2'd0, v);
              chk(k < 2 ? (k == 0 ? "R2 R4 gen" : "R3 R4 gen") : "R5 gen kept",
                  v, exp_gen(k, w[0], p[0], mark));
              rd(2'd1, v); chk("R6 upr", v, exp_upr(s, addrs[a]));
              rd(2'd2, v); chk("R7 lwr", v, addrs[a][15:0]);
              @(negedge clk);
              chk("R11 single", {15'b0, bus_err}, 16'h0000);
            end

    clear();
    rd(2'd0, v); chk("R8 gen", v, 16'hFFFF);
    rd(2'd1, v); chk("R8 upr", v, 16'hFFFF);
    rd(2'd2, v); chk("R8 lwr", v, 16'hFFFF);

    cpu_wr(2'd1, 16'h1111);
    cpu_wr(2'd2, 16'h2222);
    cpu_wr(2'd3, 16'h3333);
    rd(2'd1, v); chk("R9 upr read-only", v, 16'hFFFF);
    rd(2'd2, v); chk("R9 lwr read-only", v, 16'hFFFF);
    rd(2'd0, v); chk("R9 gen untouched", v, 16'hFFFF);
    cpu_wr(2'd0, 16'h5A5A);
    rd(2'd0, v); chk("R9 gen write", v, 16'h5A5A);

    @(negedge clk);
    reg_sel = 2'd0; reg_wdata = 16'h0F0F; reg_wr = 1'b1; clr_stb = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; clr_stb = 1'b0;
    rd(2'd0, v); chk("R8 clear beats write", v, 16'hFFFF);

    @(negedge clk);
    flt_kind = 2'd0; flt_write = 1'b1; flt_size = 2'd1; flt_addr = 24'h12ABCD;
    par_irq_en = 1'b0; flt_valid = 1'b1;
    reg_sel = 2'd0; reg_wdata = 16'h0001; reg_wr = 1'b1; clr_stb = 1'b1;
    @(negedge clk);
    flt_valid = 1'b0; reg_wr = 1'b0; clr_stb = 1'b0;
    rd(2'd0, v); chk("R10 gen fault wins", v, 16'h8BFF);
    rd(2'd1, v); chk("R10 upr fault wins", v, 16'h7C12);
    rd(2'd2, v); chk("R10 lwr fault wins", v, 16'hABCD);

    @(negedge clk);
    flt_kind = 2'd2; flt_size = 2'd0; flt_addr = 24'h340011; flt_valid = 1'b1;
    reg_sel = 2'd0; reg_wdata = 16'h4242; reg_wr = 1'b1;
    @(negedge clk);
    flt_valid = 1'b0; reg_wr = 1'b0;
    rd(2'd0, v); chk("R10 gen write with kernel fault", v, 16'h4242);
    rd(2'd1, v); chk("R10 upr kernel fault", v, 16'h7D34);

    @(negedge clk);
    flt_kind = 2'd3; flt_size = 2'd2; flt_addr = 24'h560010; flt_valid = 1'b1;
    clr_stb = 1'b1;
    @(negedge clk);
    flt_valid = 1'b0; clr_stb = 1'b0;
    rd(2'd0, v); chk("R10 gen cleared with wprot fault", v, 16'hFFFF);
    rd(2'd2, v); chk("R10 lwr wprot fault", v, 16'h0010);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule